// File: doc/BRIEF.md
# Octal Converter Register Controller

This block holds all digital state behind an eight-channel voltage-output converter. Every channel keeps a staging code and a live code. Commands move values between the two, and the live code is what the analog stage converts. The block also keeps a power-off flag for each channel and the state of the shared reference. That state is which source is selected and whether the internal source is running.

A frame receiver supplies each command as an already decoded group of three fields: operation, address and data. The receiver marks it with a one-cycle valid strobe. Three pins act on the same state: a load pin, a clear pin and the interface select level. All three are assumed to be synchronous to the block clock already.

The load pin moves every staging code into its live code. It holds all channels powered while it is low, and its action is deferred while the interface is selected. The clear pin forces every code to a build-time reset value.

For each channel the block reports a ready flag. The flag drops while the channel is off and for a settling window after the channel wakes. The window is longer when the whole converter, including its reference, was shut down.

Top module: `octdac_ctrl`

## Requirements
- R1: After reset, every live code equals the reset code, and no channel is off. The reference is selected and running exactly when REF_INT0 is 1, and every ready flag is high.
- R2: Operation 4'h0 loads the data code into the staging code of the addressed channels. Live codes do not change.
- R3: Operation 4'h1 copies staging to live for the addressed channels and clears their off flags.
- R4: Operation 4'h2 first loads the staging code of the addressed channels. It then copies staging to live for all eight channels and clears every off flag.
- R5: Operation 4'h3 loads both the staging and the live code of the addressed channels with the data code, and clears their off flags.
- R6: An address value of 0 to 7 selects the channel with that index, and 4'hF selects all channels. Operations 4'h0 to 4'h4 with any other address have no effect. Operation 4'hF and the operations 4'h8 to 4'hE have no effect.
- R7: The data code is cmd_data[15:16-RES]. The lower bits are ignored, and data has no effect for operations that do not write.
- R8: Operation 4'h4 sets the off flag of the addressed channels. Operation 4'h5 sets all off flags and stops the internal reference. Neither changes any code.
- R9: Operation 4'h6 selects the internal reference and starts it. Operation 4'h7 selects the external reference and stops the internal one.
- R10: A reference stopped by 4'h7 restarts only through 4'h6. A reference stopped by 4'h5 also restarts on any operation or load-pin event that powers a channel up.
- R11: If sel_n is high on the clock after ld_n falls, every staging code is copied to live at that clock. If sel_n is low, the copy takes place at the first clock that sees sel_n high.
- R12: While ld_n is low, every off flag is cleared on each clock, and operations 4'h4 and 4'h5 are ignored.
- R13: While clr_n is low, every staging and live code is forced to the reset code. That code is zero-scale when CLR_MID is 0 and mid-scale when it is 1. Operations are ignored during this time, and off flags and reference state are left unchanged.
- R14: A channel's ready flag rises WAKE_CH clocks after its off flag clears. If all eight channels were off and the reference was not running, the flag rises WAKE_ALL clocks after the off flag clears instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a decoded command |
| cmd_op | input | 4 | Operation field |
| cmd_addr | input | 4 | Channel address field |
| cmd_data | input | 16 | Data field, code left-justified |
| sel_n | input | 1 | Interface select level, low while a frame is being shifted |
| ld_n | input | 1 | Load pin, active low |
| clr_n | input | 1 | Clear pin, active low, level-sensitive |
| dac_code | output | 8*RES | Live codes, channel i at bits [i*RES +: RES] |
| ch_off | output | 8 | Per-channel power-off flags |
| ref_internal | output | 1 | Internal reference selected |
| ref_enabled | output | 1 | Internal reference running |
| ch_ready | output | 8 | Channel powered and settled |

## Verification
The hardest case to reach is a load-pin fall while the interface is selected. Nothing at the ports shows the copy that is waiting, so the stimulus holds sel_n low and drops ld_n. It then releases ld_n, confirms over several clocks that no live code has moved, and raises sel_n to catch the copy on the next clock. The longer settling window is also hard to reach. The stimulus gets there two ways: with a chip-wide power-off under the internal reference, and with an external reference selected followed by a power-off of every channel. Each time it counts the clocks from the off flag falling to the ready flag rising.

// File: rtl/octdac_ctrl.sv
module octdac_ctrl #(
  parameter int RES      = 12,
  parameter bit CLR_MID  = 1'b1,
  parameter bit REF_INT0 = 1'b1,
  parameter int WAKE_CH  = 1000,
  parameter int WAKE_ALL = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [3:0]       cmd_addr,
  input  logic [15:0]      cmd_data,
  input  logic             sel_n,
  input  logic             ld_n,
  input  logic             clr_n,
  output logic [8*RES-1:0] dac_code,
  output logic [7:0]       ch_off,
  output logic             ref_internal,
  output logic             ref_enabled,
  output logic [7:0]       ch_ready
);
  localparam int NCH = 8;
  localparam int TW  = $clog2(WAKE_ALL + 1);
  localparam logic [RES-1:0] RST_CODE = CLR_MID ? {1'b1, {(RES-1){1'b0}}} : '0;

  logic [RES-1:0] in_reg  [NCH];
  logic [RES-1:0] act_reg [NCH];
  logic [RES-1:0] in_nx   [NCH];
  logic [TW-1:0]  wcnt    [NCH];
  logic [NCH-1:0] hit, pu, pdm, off_nx, waking;
  logic           ld_q, ld_pend, chip_off;

  wire go         = cmd_valid & clr_n;
  wire adr_all    = cmd_addr == 4'hF;
  wire adr_ok     = adr_all | ~cmd_addr[3];
  wire a_go       = go & adr_ok;
  wire op_wr      = a_go & (cmd_op == 4'h0 || cmd_op == 4'h2 || cmd_op == 4'h3);
  wire op_upd_n   = a_go & (cmd_op == 4'h1);
  wire op_upd_all = a_go & (cmd_op == 4'h2);
  wire op_wrupd   = a_go & (cmd_op == 4'h3);
  wire op_pd_n    = a_go & (cmd_op == 4'h4) & ld_n;
  wire op_pd_chip = go & (cmd_op == 4'h5) & ld_n;
  wire op_ref_int = go & (cmd_op == 4'h6);
  wire op_ref_ext = go & (cmd_op == 4'h7);

  wire [RES-1:0] new_code = cmd_data[15 -: RES];
  wire unused_low = ^cmd_data[15-RES:0];

  wire ld_fall  = ld_q & ~ld_n;
  wire ld_now   = clr_n & sel_n & (ld_fall | ld_pend);
  wire all_down = (&ch_off) & ~ref_enabled;
  wire [TW-1:0] wake_len = all_down ? TW'(WAKE_ALL) : TW'(WAKE_CH);

  assign hit    = adr_all ? '1 : (adr_ok ? (NCH'(1) << cmd_addr[2:0]) : '0);
  assign pu     = ({NCH{op_upd_n | op_wrupd}} & hit) | {NCH{op_upd_all | ld_now | ~ld_n}};
  assign pdm    = ({NCH{op_pd_n}} & hit) | {NCH{op_pd_chip}};
  assign off_nx = (ch_off | pdm) & ~pu;
  assign waking = ch_off & ~off_nx;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      in_nx[i] = (op_wr && hit[i]) ? new_code : in_reg[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q         <= 1'b1;
      ld_pend      <= 1'b0;
      ch_off       <= '0;
      ref_internal <= REF_INT0;
      ref_enabled  <= REF_INT0;
      chip_off     <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        in_reg[i]  <= RST_CODE;
        act_reg[i] <= RST_CODE;
        wcnt[i]    <= '0;
      end
    end else begin
      ld_q    <= ld_n;
      ld_pend <= clr_n & ~sel_n & (ld_fall | ld_pend);
      ch_off  <= off_nx;

      if (op_ref_int) begin
        ref_internal <= 1'b1;
        ref_enabled  <= 1'b1;
        chip_off     <= 1'b0;
      end else if (op_ref_ext) begin
        ref_internal <= 1'b0;
        ref_enabled  <= 1'b0;
        chip_off     <= 1'b0;
      end else if (op_pd_chip && pu == '0) begin
        ref_enabled <= 1'b0;
        chip_off    <= ref_internal;
      end else if (pu != '0 && chip_off) begin
        ref_enabled <= 1'b1;
        chip_off    <= 1'b0;
      end

      for (int i = 0; i < NCH; i++) begin
        if (!clr_n) begin
          in_reg[i]  <= RST_CODE;
          act_reg[i] <= RST_CODE;
        end else begin
          in_reg[i] <= in_nx[i];
          if (ld_now || op_upd_all || ((op_upd_n || op_wrupd) && hit[i]))
            act_reg[i] <= in_nx[i];
        end
        if (off_nx[i])      wcnt[i] <= '0;
        else if (waking[i]) wcnt[i] <= wake_len;
        else if (wcnt[i] != '0) wcnt[i] <= wcnt[i] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_code[g*RES +: RES] = act_reg[g];
    assign ch_ready[g] = ~ch_off[g] & (wcnt[g] == '0);
  end
endmodule

// File: rtl/octdac_ctrl_chk.sv
module octdac_ctrl_chk #(
  parameter int RES     = 12,
  parameter bit CLR_MID = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic             ld_n,
  input logic             clr_n,
  input logic [8*RES-1:0] dac_code,
  input logic [7:0]       ch_off,
  input logic             ref_internal,
  input logic             ref_enabled,
  input logic [7:0]       ch_ready
);
  localparam logic [RES-1:0] RC = CLR_MID ? {1'b1, {(RES-1){1'b0}}} : '0;

  p_load_low_powers_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> ch_off == 8'h00);

  p_clear_forces_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> dac_code == {8{RC}});

  p_int_ref_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && clr_n && cmd_op == 4'h6) |=> (ref_internal && ref_enabled));

  p_ext_ref_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && clr_n && cmd_op == 4'h7) |=> (!ref_internal && !ref_enabled));

  p_ext_ref_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_internal && !(cmd_valid && clr_n && cmd_op == 4'h6)) |=> !ref_enabled);

  p_wake_not_ready_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ready & ~ch_off & $past(ch_off)) == 8'h00);
endmodule

bind octdac_ctrl octdac_ctrl_chk #(.RES(RES), .CLR_MID(CLR_MID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ld_n(ld_n), .clr_n(clr_n), .dac_code(dac_code), .ch_off(ch_off),
  .ref_internal(ref_internal), .ref_enabled(ref_enabled), .ch_ready(ch_ready)
);

// File: tb/test_octdac_ctrl.sv
module test_octdac_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'h0, cmd_addr = 4'h0;
  logic [15:0] cmd_data = 16'h0;
  logic sel_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [63:0] dac_code;
  logic [7:0] ch_off, ch_ready;
  logic ref_internal, ref_enabled;

  always #5 clk = ~clk;

  octdac_ctrl #(.RES(8), .CLR_MID(1'b1), .REF_INT0(1'b1), .WAKE_CH(10), .WAKE_ALL(12)) i_octdac_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .sel_n(sel_n), .ld_n(ld_n), .clr_n(clr_n), .dac_code(dac_code),
    .ch_off(ch_off), .ref_internal(ref_internal), .ref_enabled(ref_enabled), .ch_ready(ch_ready));

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] e_in [8], e_act [8];
  logic [7:0] e_off;
  bit e_ri, e_ro, e_co;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < 8; i++) chk(tag, dac_code[i*8 +: 8], e_act[i]);
    chk(tag, ch_off, e_off);
    chk(tag, ref_internal, e_ri);
    chk(tag, ref_enabled, e_ro);
  endtask

  task automatic ref_wake();
    if (e_co) begin e_ro = 1'b1; e_co = 1'b0; end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [3:0] ad, input logic [15:0] d);
    logic [7:0] h;
    logic [7:0] c;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    h = (ad == 4'hF) ? 8'hFF : ((ad < 4'd8) ? (8'd1 << ad[2:0]) : 8'h00);
    c = d[15:8];
    if (!(op <= 4'h4 && h == 8'h00)) begin
      case (op)
        4'h0: for (int i = 0; i < 8; i++) if (h[i]) e_in[i] = c;
        4'h1: begin
          for (int i = 0; i < 8; i++) if (h[i]) e_act[i] = e_in[i];
          e_off &= ~h; ref_wake();
        end
        4'h2: begin
          for (int i = 0; i < 8; i++) if (h[i]) e_in[i] = c;
          for (int i = 0; i < 8; i++) e_act[i] = e_in[i];
          e_off = 8'h00; ref_wake();
        end
        4'h3: begin
          for (int i = 0; i < 8; i++) if (h[i]) begin e_in[i] = c; e_act[i] = c; end
          e_off &= ~h; ref_wake();
        end
        4'h4: if (ld_n) e_off |= h;
        4'h5: if (ld_n) begin e_off = 8'hFF; e_ro = 1'b0; e_co = e_ri; end
        4'h6: begin e_ri = 1'b1; e_ro = 1'b1; e_co = 1'b0; end
        4'h7: begin e_ri = 1'b0; e_ro = 1'b0; e_co = 1'b0; end
        default: ;
      endcase
    end
  endtask

  task automatic wake_count(input int k, input int w, input string tag);
    int n = 0;
    while (!ch_ready[k] && n < 100) begin @(negedge clk); n++; end
    chk(tag, n, w);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin e_in[i] = 8'h80; e_act[i] = 8'h80; end
    e_off = 8'h00; e_ri = 1'b1; e_ro = 1'b1; e_co = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    chk("R1 ready", ch_ready, 8'hFF);

    for (int ch = 0; ch < 8; ch++) begin
      logic [7:0] v;
      v = 8'((ch * 37 + 11) & 255);
      do_cmd(4'h0, 4'(ch), {v, 8'hA5});
      check_state("R2 write staging only");
      do_cmd(4'h1, 4'(ch), 16'h0000);
      check_state("R3 R7 update ignores data");
      do_cmd(4'h3, 4'(ch), {~v, 8'h5A});
      check_state("R5 R7 write and update");
    end

    do_cmd(4'h0, 4'h0, 16'h1111);
    do_cmd(4'h0, 4'h7, 16'h7777);
    do_cmd(4'h1, 4'hF, 16'hFFFF);
    check_state("R3 update all");

    do_cmd(4'h3, 4'h9, 16'hEE00);
    check_state("R6 reserved address");
    do_cmd(4'hA, 4'h0, 16'hDD00);
    check_state("R6 reserved op");
    do_cmd(4'hF, 4'h3, 16'hCC00);
    check_state("R6 no-op");

    do_cmd(4'h0, 4'h5, 16'h5F00);
    do_cmd(4'h0, 4'h1, 16'h1F00);
    do_cmd(4'h2, 4'h2, 16'h2200);
    check_state("R4 write then update all");

    do_cmd(4'h4, 4'h3, 16'hFFFF);
    check_state("R8 channel off keeps codes");
    chk("R14 off not ready", ch_ready[3], 0);
    do_cmd(4'h1, 4'h3, 16'h0000);
    check_state("R3 power up channel");
    wake_count(3, 10, "R14 single wake");

    do_cmd(4'h5, 4'h0, 16'h0000);
    check_state("R8 chip off");
    do_cmd(4'h1, 4'h0, 16'h0000);
    check_state("R10 chip-off ref restarts on update");
    wake_count(0, 12, "R14 all-down wake");
    do_cmd(4'h1, 4'hF, 16'h0000);

    do_cmd(4'h7, 4'h0, 16'h0000);
    check_state("R9 external ref");
    do_cmd(4'h1, 4'h1, 16'h0000);
    check_state("R10 external ref stays off");
    do_cmd(4'h5, 4'h0, 16'h0000);
    do_cmd(4'h1, 4'hF, 16'h0000);
    check_state("R10 update does not restart after external");
    wake_count(7, 12, "R14 all-down external wake");
    do_cmd(4'h6, 4'h0, 16'h0000);
    check_state("R9 internal ref");

    do_cmd(4'h4, 4'h1, 16'h0000);
    do_cmd(4'h0, 4'h4, 16'h4400);
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) e_act[i] = e_in[i];
    e_off = 8'h00;
    check_state("R11 R12 immediate load");
    do_cmd(4'h4, 4'h2, 16'h0000);
    check_state("R12 power-off ignored");
    do_cmd(4'h5, 4'h0, 16'h0000);
    check_state("R12 chip-off ignored");
    @(negedge clk); ld_n = 1'b1;

    do_cmd(4'h0, 4'h6, 16'h6600);
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk); ld_n = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R11 deferred while selected");
    ld_n = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R11 still deferred");
    sel_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) e_act[i] = e_in[i];
    check_state("R11 deferred copy");

    do_cmd(4'h4, 4'h5, 16'h0000);
    @(negedge clk);
    clr_n = 1'b0; cmd_valid = 1'b1; cmd_op = 4'h3; cmd_addr = 4'h0; cmd_data = 16'h3300;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin e_in[i] = 8'h80; e_act[i] = 8'h80; end
    check_state("R13 clear forces code");
    @(negedge clk); clr_n = 1'b1;
    @(negedge clk);
    check_state("R13 after clear");
    do_cmd(4'h1, 4'hF, 16'h0000);
    check_state("R13 staging cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule